// File: doc/BRIEF.md
# Serial Byte-Complete Flag Controller

This block keeps the status flags of a byte-oriented two-wire serial engine. The flags are data-register-empty, data-register-full, interrupt and transfer-request. The engine sends a one-cycle pulse at the end of every byte. With the pulse it gives the byte's direction and the acknowledge bit it sampled. From these inputs the block sets the flags. It raises a request to a data-transfer controller and, when enabled, an interrupt to the CPU.

The acknowledge-enable control sets what happens after a transmitted byte that was not acknowledged. With the control off, every transmitted byte is handed to the transfer controller. With it on, a not-acknowledged byte raises only the interrupt flag. No transfer request follows, so software sees the fault.

The completion handshake from the transfer controller clears the empty, interrupt and request flags at once. This means a run of continuous transfers never reaches the CPU. Software can clear the interrupt flag by itself. A read of the data register clears the full flag. A set always wins over a clear in the same cycle, so no byte completion is lost.

Top module: `byte_flag_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all four flags, `status_word`, `xfer_req` and `cpu_irq` are 0.
- R2: When `ack_en` is 0, a transmit byte end (`byte_done`=1, `byte_tx`=1) sets the empty, interrupt and request flags on the next clock edge, for either value of `ack_bit`.
- R3: When `ack_en` is 1 and `ack_bit` is 0, a transmit byte end sets the empty, interrupt and request flags.
- R4: When `ack_en` is 1 and `ack_bit` is 1, a transmit byte end sets only the interrupt flag. The request and empty flags keep their previous values.
- R5: A receive byte end (`byte_done`=1, `byte_tx`=0) sets the full, interrupt and request flags, whatever `ack_en` and `ack_bit` are. The empty flag is unchanged.
- R6: `xfer_done` clears the empty, interrupt and request flags on the next edge. It leaves the full flag unchanged.
- R7: `sw_clr_irq` clears only the interrupt flag.
- R8: `data_read` clears only the full flag.
- R9: If a byte end sets a flag in the same cycle that a clear input targets it, the flag ends up 1.
- R10: `xfer_req` equals the request flag in every cycle.
- R11: `cpu_irq` = interrupt flag AND `irq_en` AND NOT (request flag AND `xfer_en`).
- R12: `status_word` packs the flags as bit 0 empty, bit 1 full, bit 2 interrupt, bit 3 request. Each bit matches its own flag output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| byte_done | input | 1 | One-cycle pulse at the end of a byte |
| byte_tx | input | 1 | Direction of the finished byte: 1 transmit, 0 receive |
| ack_bit | input | 1 | Sampled acknowledge bit (1 = not acknowledged) |
| ack_en | input | 1 | Acknowledge-enable policy control |
| irq_en | input | 1 | CPU interrupt enable |
| xfer_en | input | 1 | Transfer controller is enabled to serve requests |
| xfer_done | input | 1 | Transfer controller completion pulse |
| sw_clr_irq | input | 1 | Software write of 0 to the interrupt flag |
| data_read | input | 1 | Data register read by software or the controller |
| flag_empty | output | 1 | Data-register-empty flag |
| flag_full | output | 1 | Data-register-full flag |
| flag_irq | output | 1 | Interrupt flag |
| flag_req | output | 1 | Transfer-request flag |
| xfer_req | output | 1 | Request to the transfer controller |
| cpu_irq | output | 1 | Interrupt to the CPU |
| status_word | output | 4 | All flags packed as one word |

## Verification
The bench steps through all 512 combinations of the nine inputs. It visits them in a scrambled order so that each combination starts from a different flag state. The direction, `ack_en` and `ack_bit` patterns separate the four set policies: transmit with the policy off, acknowledged transmit, not-acknowledged transmit, and receive. The combinations that pulse a clear together with a byte end separate set-wins priority from clear priority. The `irq_en` and `xfer_en` levels, tried against every flag state, separate an interrupt that is gated by a pending request from one that reaches the CPU.

// File: rtl/bfc_pkg.sv
// Package: shared flag layout of the byte-complete flag controller.
// Assumes: status word order is empty, full, interrupt, request (LSB first).
package bfc_pkg;
    localparam int FLAG_W   = 4;
    localparam int IDX_EMPTY = 0;
    localparam int IDX_FULL  = 1;
    localparam int IDX_IRQ   = 2;
    localparam int IDX_REQ   = 3;

    typedef struct packed {
        logic req;
        logic irq;
        logic full;
        logic empty;
    } bfc_flags_t;
endpackage

// File: rtl/bfc_set_policy.sv
// Module: decodes one byte-end event into a flag set vector.
// Assumes: byte_done is a single-cycle pulse; ack_bit=1 means not acknowledged.
module bfc_set_policy
    import bfc_pkg::*;
(
    input  logic              byte_done,
    input  logic              byte_tx,
    input  logic              ack_bit,
    input  logic              ack_en,
    output logic [FLAG_W-1:0] set_vec
);
    logic tx_handoff;

    // Purpose: choose which flags a finished byte raises under the ack policy.
    always_comb begin
        tx_handoff         = !ack_en || !ack_bit;
        set_vec            = '0;
        set_vec[IDX_IRQ]   = byte_done;
        set_vec[IDX_EMPTY] = byte_done && byte_tx && tx_handoff;
        set_vec[IDX_FULL]  = byte_done && !byte_tx;
        set_vec[IDX_REQ]   = byte_done && (!byte_tx || tx_handoff);
    end
endmodule

// File: rtl/bfc_flag_cell.sv
// Module: bank of set/clear flag registers where set has priority.
// Assumes: synchronous active-low reset; set and clear vectors are per bit.
module bfc_flag_cell #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] q_vec
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        // Purpose: hold one flag; a set in the same cycle beats a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q_vec[g] <= 1'b0;
            else if (set_vec[g])
                q_vec[g] <= 1'b1;
            else if (clr_vec[g])
                q_vec[g] <= 1'b0;
        end

        // R9: a set always lands, even alongside a clear
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[g] |=> q_vec[g]);
        // R6 R7 R8: a clear without a set empties the flag
        a_r6_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[g] && !set_vec[g]) |=> !q_vec[g]);
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_vec[g] && !set_vec[g]) |=> $stable(q_vec[g]));
    end
endmodule

// File: rtl/bfc_irq_gate.sv
// Module: forms the transfer request and the gated CPU interrupt.
// Assumes: an enabled transfer controller services a pending request first.
module bfc_irq_gate (
    input  logic irq_flag,
    input  logic req_flag,
    input  logic irq_en,
    input  logic xfer_en,
    output logic xfer_req,
    output logic cpu_irq
);
    // Purpose: hold off the CPU while the controller will clear the flags.
    always_comb begin
        xfer_req = req_flag;
        cpu_irq  = irq_flag && irq_en && !(req_flag && xfer_en);
    end
endmodule

// File: rtl/byte_flag_ctrl.sv
// Module: top of the serial byte-complete flag controller.
// Assumes: all event inputs are synchronous single-cycle pulses on clk.
module byte_flag_ctrl
    import bfc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic              byte_tx,
    input  logic              ack_bit,
    input  logic              ack_en,
    input  logic              irq_en,
    input  logic              xfer_en,
    input  logic              xfer_done,
    input  logic              sw_clr_irq,
    input  logic              data_read,
    output logic              flag_empty,
    output logic              flag_full,
    output logic              flag_irq,
    output logic              flag_req,
    output logic              xfer_req,
    output logic              cpu_irq,
    output logic [FLAG_W-1:0] status_word
);
    logic [FLAG_W-1:0] set_vec;
    logic [FLAG_W-1:0] clr_vec;
    logic [FLAG_W-1:0] flag_q;
    bfc_flags_t        flags;

    bfc_set_policy u_policy (
        .byte_done (byte_done),
        .byte_tx   (byte_tx),
        .ack_bit   (ack_bit),
        .ack_en    (ack_en),
        .set_vec   (set_vec)
    );

    // Purpose: map each clear source onto the flags it empties.
    always_comb begin
        clr_vec            = '0;
        clr_vec[IDX_EMPTY] = xfer_done;
        clr_vec[IDX_FULL]  = data_read;
        clr_vec[IDX_IRQ]   = xfer_done || sw_clr_irq;
        clr_vec[IDX_REQ]   = xfer_done;
    end

    bfc_flag_cell #(.WIDTH(FLAG_W)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .q_vec   (flag_q)
    );

    // Purpose: expose the flag bank as named flags and one status word.
    always_comb begin
        flags       = bfc_flags_t'(flag_q);
        flag_empty  = flags.empty;
        flag_full   = flags.full;
        flag_irq    = flags.irq;
        flag_req    = flags.req;
        status_word = flag_q;
    end

    bfc_irq_gate u_gate (
        .irq_flag (flags.irq),
        .req_flag (flags.req),
        .irq_en   (irq_en),
        .xfer_en  (xfer_en),
        .xfer_req (xfer_req),
        .cpu_irq  (cpu_irq)
    );

    // R2: with the ack policy off, a transmit byte hands off to the controller
    a_r2_tx_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_tx && !ack_en) |=> (flag_empty && flag_irq && flag_req));
    // R4: a not-acknowledged byte under the policy makes no new request
    a_r4_nack_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && byte_tx && ack_en && ack_bit && !flag_req) |=> (!flag_req && flag_irq));
    // R5: a received byte fills the data register
    a_r5_rx_full: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !byte_tx) |=> (flag_full && flag_req));
    // R6: completion without a new byte empties all three handshake flags
    a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !byte_done) |=> (!flag_empty && !flag_irq && !flag_req));
    // R11: no CPU interrupt while an enabled controller has a request pending
    a_r11_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_req && xfer_en) |-> !cpu_irq);
    // R1: flags are empty after reset
    a_r1_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (status_word == '0));
endmodule

// File: tb/byte_flag_ctrl_tb.sv
module byte_flag_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic byte_done = 0, byte_tx = 0, ack_bit = 0, ack_en = 0;
    logic irq_en = 0, xfer_en = 0, xfer_done = 0, sw_clr_irq = 0, data_read = 0;
    logic flag_empty, flag_full, flag_irq, flag_req, xfer_req, cpu_irq;
    logic [3:0] status_word;

    int n_checks = 0;
    int n_fail = 0;
    logic [3:0] exp_st = 4'b0;

    always #2.5 clk = ~clk;

    byte_flag_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .byte_tx(byte_tx),
        .ack_bit(ack_bit), .ack_en(ack_en), .irq_en(irq_en), .xfer_en(xfer_en),
        .xfer_done(xfer_done), .sw_clr_irq(sw_clr_irq), .data_read(data_read),
        .flag_empty(flag_empty), .flag_full(flag_full), .flag_irq(flag_irq),
        .flag_req(flag_req), .xfer_req(xfer_req), .cpu_irq(cpu_irq),
        .status_word(status_word)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Compare every output against the expected flag state.
    task automatic check_all(input string req);
        check(req, status_word, exp_st);
        check("R12", {flag_req, flag_irq, flag_full, flag_empty}, exp_st);
        check("R10", {3'b0, xfer_req}, {3'b0, exp_st[3]});
        check("R11", {3'b0, cpu_irq},
              {3'b0, exp_st[2] & irq_en & ~(exp_st[3] & xfer_en)});
    endtask

    // Apply one input vector for one edge, then sample at the next falling edge.
    task automatic step(input logic [8:0] v);
        string req;
        logic se, sf, si, sr;
        @(negedge clk);
        {byte_done, byte_tx, ack_bit, ack_en, xfer_done,
         sw_clr_irq, data_read, irq_en, xfer_en} = v;
        si = byte_done;
        se = byte_done & byte_tx & (~ack_en | ~ack_bit);
        sf = byte_done & ~byte_tx;
        sr = byte_done & (~byte_tx | ~ack_en | ~ack_bit);
        if (byte_done && (xfer_done || sw_clr_irq || data_read)) req = "R9";
        else if (byte_done && byte_tx && !ack_en) req = "R2";
        else if (byte_done && byte_tx && ack_bit) req = "R4";
        else if (byte_done && byte_tx) req = "R3";
        else if (byte_done) req = "R5";
        else if (xfer_done) req = "R6";
        else if (sw_clr_irq) req = "R7";
        else if (data_read) req = "R8";
        else req = "R12";
        exp_st[0] = se | (exp_st[0] & ~xfer_done);
        exp_st[1] = sf | (exp_st[1] & ~data_read);
        exp_st[2] = si | (exp_st[2] & ~(xfer_done | sw_clr_irq));
        exp_st[3] = sr | (exp_st[3] & ~xfer_done);
        @(negedge clk);
        byte_done = 0; xfer_done = 0; sw_clr_irq = 0; data_read = 0;
        #0.5;
        check_all(req);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        #0.5;
        check_all("R1");
        rst_n = 1'b1;

        // R4 directed: nack under policy raises only the interrupt
        step(9'b1_1_1_1_0_0_0_1_1);
        // R7 directed: software clears the interrupt
        step(9'b0_0_0_0_0_1_0_1_0);
        // R2 directed: policy off, nack still hands off
        step(9'b1_1_1_0_0_0_0_1_1);
        // R6 directed: completion clears the three flags
        step(9'b0_0_0_0_1_0_0_1_1);
        // R5 then R8 directed
        step(9'b1_0_1_1_0_0_0_1_0);
        step(9'b0_0_0_0_0_0_1_1_0);

        // Exhaustive sweep in scrambled order, two passes
        for (int pass = 0; pass < 2; pass++) begin
            for (int i = 0; i < 512; i++) begin
                step(9'((i * 37 + pass * 101) % 512));
            end
        end

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        exp_st = 4'b0;
        #0.5;
        check_all("R1");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule